// File: doc/BRIEF.md
# Slot Status Error Counter

This block keeps one running tally per bus channel. Each tally counts the communication slots or segments that ended with a protocol fault. A slot counts as faulty when any of its four error indicators is set. The slot kinds are static slots, dynamic slots, the symbol window and the network idle time. Each slot adds at most one to its channel's tally, however many indicators were raised in it.

A single-cycle boundary strobe marks the end of each slot. On that strobe the block captures the indicators into a pending bit. The increment becomes visible on the first macrotick strobe that arrives in a later cycle. This places the update inside the first macrotick of the following slot. Both tallies are 16 bits wide and wrap around.

A host reads the tallies over a registered read port; there is no write path. The tallies return to zero on reset, and also whenever the controller is given its run command.

Top module: `slot_err_counter`

## Requirements
- R1: After `rst_n` is held low, both channel tallies read 0.
- R2: A slot whose captured flags are nonzero adds exactly 1 to its channel's tally, whatever the number of set bits. The flag bits are bit0 syntax error, bit1 content error, bit2 boundary violation and bit3 transmit conflict.
- R3: A slot whose captured flags are all zero leaves the tally unchanged.
- R4: Flags are captured in the cycle `slot_end` is high. The increment appears after the first `mt_tick` in a later cycle. An `mt_tick` in the same cycle as `slot_end` does not commit the slot being captured.
- R5: If a new `slot_end` arrives while an increment is still pending, the pending increment is applied in that cycle and the new flags are captured.
- R6: The tally wraps from 0xFFFF to 0x0000.
- R7: `run_cmd` clears both tallies and every pending increment in the next cycle. It takes priority over an increment due in the same cycle.
- R8: Strobes and flags of one channel never change the other channel's tally.
- R9: A read with `rd_en` high loads `rd_data` on the next clock edge. Address 0x24 gives channel 0 (A), 0x26 gives channel 1 (B), and any other address gives 0. `rd_data` holds its value while `rd_en` is low.
- R10: A tally changes only in a cycle with `slot_end`, `mt_tick` or `run_cmd` on its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_cmd | input | 1 | Controller run command; clears both tallies |
| slot_end | input | 2 | Per-channel slot boundary strobe |
| mt_tick | input | 2 | Per-channel macrotick strobe |
| slot_flags | input | 2x4 | Per-channel error indicators for the ending slot |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Registered read result |

## Verification
A vector table drives slots with no flags, with single flags in each bit position and with all four flags set. It alternates between channels, so that adding per slot is told apart from adding per flag, and each channel's tally is told apart from the other's. Directed cases separate capture from commit. They read the tally between the boundary and the macrotick, put a tick in the same cycle as the boundary, and send back-to-back boundaries. A run command together with a due increment checks clear priority, and a 65536-slot burst reaches the wrap.

// File: rtl/slot_err_pkg.sv
// Shared definitions for the slot status error counter.
// Assumes: four error indicators per slot, in a fixed bit order.
package slot_err_pkg;

    localparam int FLAG_W = 4;

    // Error indicators of one slot; bit0 is syntax error.
    typedef struct packed {
        logic tx_conflict;
        logic bound_viol;
        logic content_err;
        logic syntax_err;
    } slot_flags_t;

endpackage

// File: rtl/slot_err_channel.sv
// One channel's tally. It captures a slot's fault flag at the boundary
// strobe and commits it on the next macrotick in a later cycle.
// Assumes: strobes are single-cycle pulses synchronous to clk.
module slot_err_channel
    import slot_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             slot_end,
    input  logic             mt_tick,
    input  slot_flags_t      flags,
    output logic [CNT_W-1:0] count
);

    logic pending_q;
    logic faulty;
    logic commit;

    // Any indicator set marks the slot as faulty.
    assign faulty = flags.syntax_err | flags.content_err |
                    flags.bound_viol | flags.tx_conflict;

    // A pending slot commits on a tick or when a newer boundary displaces it.
    assign commit = pending_q & (mt_tick | slot_end);

    // Pending-slot register: capture at the boundary, drop on tick or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pending_q <= 1'b0;
        end else if (slot_end) begin
            pending_q <= faulty;
        end else if (mt_tick) begin
            pending_q <= 1'b0;
        end
    end

    // Tally register: wraps naturally at its width.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (commit) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/slot_err_readport.sv
// Registered read multiplexer over all channel tallies.
// Assumes: channel c sits at byte offset BASE_ADDR + STRIDE*c.
module slot_err_readport #(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h24,
    parameter int STRIDE    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
    output logic [CNT_W-1:0]             rd_data
);

    logic [CNT_W-1:0] sel_val;

    // Address decode: unmapped offsets yield zero.
    always_comb begin
        sel_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(BASE_ADDR + STRIDE * c)) begin
                sel_val = counts[c];
            end
        end
    end

    // Read data register: loads only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_val;
        end
    end

endmodule

// File: rtl/slot_err_counter.sv
// Top of the slot status error counter: one tally per channel plus a
// read port. The run command clears every channel.
// Assumes: per-channel strobes are already synchronous to clk.
module slot_err_counter
    import slot_err_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h24,
    parameter int STRIDE    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_cmd,
    input  logic [NUM_CH-1:0]             slot_end,
    input  logic [NUM_CH-1:0]             mt_tick,
    input  logic [NUM_CH-1:0][FLAG_W-1:0] slot_flags,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [CNT_W-1:0]              rd_data
);

    logic [NUM_CH-1:0][CNT_W-1:0] ch_count;

    // One independent tally per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        slot_err_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (run_cmd),
            .slot_end (slot_end[c]),
            .mt_tick  (mt_tick[c]),
            .flags    (slot_flags_t'(slot_flags[c])),
            .count    (ch_count[c])
        );
    end

    slot_err_readport #(
        .NUM_CH    (NUM_CH),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .STRIDE    (STRIDE)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .counts  (ch_count),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/slot_err_checker.sv
// Temporal checks for slot_err_counter, attached by bind.
module slot_err_checker #(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h24,
    parameter int STRIDE    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         run_cmd,
    input logic [NUM_CH-1:0]            slot_end,
    input logic [NUM_CH-1:0]            mt_tick,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [CNT_W-1:0]             rd_data,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_count
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE_ADDR + STRIDE * c);

        // R7
        run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_cmd |=> (ch_count[c] == '0));

        // R10
        quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_cmd && !slot_end[c] && !mt_tick[c]) |=> $stable(ch_count[c]));

        // R2
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run_cmd |=> (ch_count[c] == $past(ch_count[c]) ||
                          ch_count[c] == CNT_W'($past(ch_count[c]) + 1'b1)));

        // R9
        read_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == CH_ADDR) |=> (rd_data == $past(ch_count[c])));
    end

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind slot_err_counter slot_err_checker #(
    .NUM_CH    (NUM_CH),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .STRIDE    (STRIDE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_cmd  (run_cmd),
    .slot_end (slot_end),
    .mt_tick  (mt_tick),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ch_count (ch_count)
);

// File: tb/slot_err_counter_bench.sv
// Self-checking bench: a vector table of slots, then directed corner cases.
module slot_err_counter_bench;

    localparam logic [7:0] ADDR_A = 8'h24;
    localparam logic [7:0] ADDR_B = 8'h26;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_cmd = 1'b0;
    logic [1:0]       slot_end = '0;
    logic [1:0]       mt_tick = '0;
    logic [1:0][3:0]  slot_flags = '0;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_addr = '0;
    logic [15:0]      rd_data;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_a = '0;
    logic [15:0] exp_b = '0;
    logic [15:0] got;

    always #10 clk = ~clk;

    slot_err_counter u_slot_err_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_cmd    (run_cmd),
        .slot_end   (slot_end),
        .mt_tick    (mt_tick),
        .slot_flags (slot_flags),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // Table entry: [36] channel, [35:32] flags, [31:16] tally A, [15:0] tally B.
    localparam logic [36:0] VEC [8] = '{
        {1'b0, 4'b0000, 16'd0, 16'd0},
        {1'b0, 4'b0001, 16'd1, 16'd0},
        {1'b0, 4'b1111, 16'd2, 16'd0},
        {1'b1, 4'b0100, 16'd2, 16'd1},
        {1'b1, 4'b0000, 16'd2, 16'd1},
        {1'b0, 4'b1000, 16'd3, 16'd1},
        {1'b1, 4'b0010, 16'd3, 16'd2},
        {1'b0, 4'b0010, 16'd4, 16'd2}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] addr, output logic [15:0] val);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = addr;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic boundary(input int ch, input logic [3:0] fl, input logic with_tick);
        @(negedge clk);
        slot_end[ch] = 1'b1;
        slot_flags[ch] = fl;
        mt_tick[ch] = with_tick;
        @(negedge clk);
        slot_end[ch] = 1'b0;
        slot_flags[ch] = '0;
        mt_tick[ch] = 1'b0;
    endtask

    task automatic tick(input int ch);
        @(negedge clk);
        mt_tick[ch] = 1'b1;
        @(negedge clk);
        mt_tick[ch] = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both channels
        read_reg(ADDR_A, got); check("R1 tally A after reset", got, 16'd0);
        read_reg(ADDR_B, got); check("R1 tally B after reset", got, 16'd0);

        // R2 R3 R8: table of slots on alternating channels
        for (int i = 0; i < 8; i++) begin
            boundary(int'(VEC[i][36]), VEC[i][35:32], 1'b0);
            tick(int'(VEC[i][36]));
            read_reg(ADDR_A, got); check("R2/R3/R8 table tally A", got, VEC[i][31:16]);
            read_reg(ADDR_B, got); check("R2/R3/R8 table tally B", got, VEC[i][15:0]);
        end
        exp_a = 16'd4;
        exp_b = 16'd2;

        // R4: capture without tick does not count yet; the tick commits it
        boundary(0, 4'b0010, 1'b0);
        read_reg(ADDR_A, got); check("R4 before tick", got, exp_a);
        tick(0); exp_a++;
        read_reg(ADDR_A, got); check("R4 after tick", got, exp_a);

        // R4: tick in the boundary cycle does not commit the captured slot
        boundary(0, 4'b0100, 1'b1);
        read_reg(ADDR_A, got); check("R4 same-cycle tick", got, exp_a);
        tick(0); exp_a++;
        read_reg(ADDR_A, got); check("R4 later tick", got, exp_a);

        // R5: back-to-back boundaries commit the earlier slot
        boundary(1, 4'b0001, 1'b0);
        boundary(1, 4'b1000, 1'b0); exp_b++;
        read_reg(ADDR_B, got); check("R5 displaced commit", got, exp_b);
        tick(1); exp_b++;
        read_reg(ADDR_B, got); check("R5 second slot", got, exp_b);

        // R9: read data holds while rd_en is low even as tally A moves
        boundary(0, 4'b0001, 1'b0);
        tick(0); exp_a++;
        @(negedge clk);
        check("R9 hold without rd_en", rd_data, exp_b);
        read_reg(ADDR_A, got); check("R9 tally A read", got, exp_a);

        // R9: unmapped offsets read zero
        read_reg(8'h25, got); check("R9 offset 0x25", got, 16'd0);
        read_reg(8'h28, got); check("R9 offset 0x28", got, 16'd0);

        // R7: run command beats an increment due in the same cycle
        boundary(0, 4'b1111, 1'b0);
        @(negedge clk);
        run_cmd = 1'b1;
        mt_tick[0] = 1'b1;
        @(negedge clk);
        run_cmd = 1'b0;
        mt_tick[0] = 1'b0;
        read_reg(ADDR_A, got); check("R7 tally A cleared", got, 16'd0);
        read_reg(ADDR_B, got); check("R7 tally B cleared", got, 16'd0);
        tick(0);
        read_reg(ADDR_A, got); check("R7 pending dropped", got, 16'd0);

        // R8 setup: give B a nonzero value to prove it stays put
        boundary(1, 4'b0100, 1'b1);
        tick(1);
        exp_b = 16'd1;

        // R6: 65536 back-to-back faulty boundaries reach 0xFFFF, a tick wraps
        @(negedge clk);
        slot_end[0] = 1'b1;
        slot_flags[0] = 4'b0001;
        repeat (65536) @(negedge clk);
        slot_end[0] = 1'b0;
        slot_flags[0] = '0;
        read_reg(ADDR_A, got); check("R6 tally at max", got, 16'hFFFF);
        read_reg(ADDR_B, got); check("R8 B untouched by A burst", got, exp_b);
        tick(0);
        read_reg(ADDR_A, got); check("R6 wrap to zero", got, 16'd0);

        // R1: a fresh reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(ADDR_B, got); check("R1 tally B after second reset", got, 16'd0);

        finish_run();
    end

endmodule